// File: doc/BRIEF.md
# Static Interleaved Timeslot Sequencer

This block picks which hardware thread issues on each clock of a core. There are three realtime lanes (A, B, C) and one best-effort lane (D). A free-running eight-step slot counter gives each cycle an owner. Lane A owns every second cycle, lane B every fourth, and lanes C and D every eighth. When the realtime owner of a slot is missing or asleep, that cycle goes to lane D. A realtime thread therefore keeps the same cycle-exact timing no matter what the other lanes are doing.

Each issued realtime instruction reports back a 2-bit delay field. The sequencer scales that field by the thread's shift to get the number of cycles until the thread may issue again. It then puts the lane to sleep for exactly that span. Every scaled delay is a multiple of the lane's period, so the wake-up always lands on one of the lane's own slots. A separate combinational check, with a registered result, validates requests to launch a thread or change a thread's shift. It rejects any shift that the target lane cannot serve, and it rejects any conflict over occupancy.

Top module: `tsq_sequencer`

## Requirements
- R1: Lane codes are A=0, B=1, C=2, D=3. The slot owner for counter value k (mod 8) is A when k is even, B when k mod 4 = 1, C when k = 3 and D when k = 7. The first registered `sel_lane` after reset release belongs to k = 0, and each following cycle advances k by one.
- R2: When the slot owner is a realtime lane that is occupied and not asleep, `sel_lane` equals that lane.
- R3: When the slot owner is D, or is a realtime lane that is unoccupied or asleep, `sel_lane` is 3.
- R4: When `iss_valid` is high while `sel_lane` shows realtime lane X, X sleeps. Its next issue comes exactly d cycles after that issue, with d = (`iss_delay`+1) << shift of X. This gives 2/4/6/8 at shift 1, 4/8/12/16 at shift 2 and 8/16/24/32 at shift 3.
- R5: `iss_valid` while `sel_lane` is 3 puts no lane to sleep.
- R6: A request is rejected when the target lane is 3, when the shift is 0, or when the shift is below the lane's minimum: A needs 1, B needs 2, C needs 3. The verdict appears on `adm_err` one cycle after the request.
- R7: A launch (`req_change`=0) into an occupied lane is rejected. In particular, a launch at shift 1 is rejected while lane A is occupied.
- R8: A shift change (`req_change`=1) on an unoccupied lane is rejected. The thread in lane A may change itself to shift 1.
- R9: Reset drives `sel_lane` to 3 and `adm_err` to 0. A cycle with no request leaves `adm_err` at 0 the next cycle.
- R10: A lane whose occupancy drops loses any pending sleep. A thread launched into it later is ready at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_occ | input | 3 | Realtime lane occupancy, bit 0 = A |
| lane_shift | input | 6 | Shift per realtime lane, bits [1:0] = A |
| iss_valid | input | 1 | The lane shown on `sel_lane` issued this cycle |
| iss_delay | input | 2 | Delay field of that instruction |
| req_valid | input | 1 | Admission request present |
| req_change | input | 1 | 0 = launch, 1 = shift change |
| req_lane | input | 2 | Target lane code |
| req_shift | input | 2 | Requested shift |
| sel_lane | output | 2 | Registered issuing lane |
| adm_err | output | 1 | Registered rejection of last cycle's request |

## Verification
The hardest case to reach is a sleep long enough to span several of the lane's own slots. Lane B at delay 12 must let two of its slots fall through to D and then issue on exactly the third. Lane C at delay 16 must skip one full eight-cycle round. The bench reaches these cases by counting cycles from reset release, raising the delay feedback in the cycle the lane is shown, and then checking every later slot up to the wake-up. A short drop in occupancy during a 32-cycle sleep shows that the pending delay is cleared.

// File: rtl/tsq_pkg.sv
`timescale 1ns/1ps
package tsq_pkg;
  localparam int NRT     = 3;   // realtime lanes
  localparam int SLOT_CW = 3;   // eight-step slot counter

  typedef enum logic [1:0] {
    LANE_A = 2'd0,
    LANE_B = 2'd1,
    LANE_C = 2'd2,
    LANE_D = 2'd3
  } lane_e;

  function automatic lane_e slot_owner(input logic [SLOT_CW-1:0] c);
    if (!c[0])              return LANE_A;
    else if (c[1:0] == 2'b01) return LANE_B;
    else if (c == 3'd3)     return LANE_C;
    else                    return LANE_D;
  endfunction

  function automatic int min_shift(input logic [1:0] lane);
    case (lane)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/tsq_slot_gen.sv
`timescale 1ns/1ps
module tsq_slot_gen
  import tsq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  output logic [SLOT_CW-1:0] slot_cnt,
  output lane_e              slot_lane
);
  always_ff @(posedge clk) begin
    if (rst) slot_cnt <= '0;
    else     slot_cnt <= slot_cnt + 1'b1;
  end

  assign slot_lane = slot_owner(slot_cnt);
endmodule

// File: rtl/tsq_wake_timer.sv
`timescale 1ns/1ps
module tsq_wake_timer #(
  parameter int MDW  = 2,
  parameter int SHW  = 2,
  parameter int DLYW = MDW + (1 << SHW)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           occ,
  input  logic [SHW-1:0] shift,
  input  logic           load,
  input  logic [MDW-1:0] field,
  output logic           ready
);
  logic [DLYW-1:0] delay;
  logic [DLYW-1:0] load_val;
  logic [DLYW-1:0] rem;

  // The load happens one cycle after the issue slot, and readiness is
  // sampled at the wake edge, hence the offset of two.
  assign delay    = (DLYW'(field) + DLYW'(1)) << shift;
  assign load_val = (delay >= DLYW'(2)) ? delay - DLYW'(2) : '0;

  always_ff @(posedge clk) begin
    if (rst)              rem <= '0;
    else if (!occ)        rem <= '0;
    else if (load)        rem <= load_val;
    else if (rem != '0)   rem <= rem - 1'b1;
  end

  assign ready = occ && (rem == '0);
endmodule

// File: rtl/tsq_admit.sv
`timescale 1ns/1ps
module tsq_admit
  import tsq_pkg::*;
#(
  parameter int SHW = 2
) (
  input  logic           change,
  input  logic [1:0]     lane,
  input  logic [SHW-1:0] shift,
  input  logic [NRT-1:0] occ,
  output logic           bad
);
  logic [3:0] occ4;
  logic       tgt_occ;
  logic       lane_bad, shift_low, launch_busy, change_empty, a_conflict;

  assign occ4         = {1'b0, occ};
  assign tgt_occ      = occ4[lane];
  assign lane_bad     = (lane == LANE_D);
  assign shift_low    = (shift == '0) || (int'(shift) < min_shift(lane));
  assign launch_busy  = !change && tgt_occ;
  assign change_empty = change && !tgt_occ;
  assign a_conflict   = (shift == SHW'(1)) && occ[0] && !(change && lane == LANE_A);
  assign bad = lane_bad | shift_low | launch_busy | change_empty | a_conflict;
endmodule

// File: rtl/tsq_sequencer.sv
`timescale 1ns/1ps
module tsq_sequencer
  import tsq_pkg::*;
#(
  parameter int MDW = 2,
  parameter int SHW = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NRT-1:0]     lane_occ,
  input  logic [NRT*SHW-1:0] lane_shift,
  input  logic               iss_valid,
  input  logic [MDW-1:0]     iss_delay,
  input  logic               req_valid,
  input  logic               req_change,
  input  logic [1:0]         req_lane,
  input  logic [SHW-1:0]     req_shift,
  output logic [1:0]         sel_lane,
  output logic               adm_err
);
  logic [SLOT_CW-1:0] slot_cnt;
  lane_e              slot_lane;
  logic [NRT-1:0]     rt_ready;
  logic [3:0]         rdy4;
  lane_e              pick;
  lane_e              sel_q;
  logic               req_bad;

  tsq_slot_gen u_slot (
    .clk       (clk),
    .rst       (rst),
    .slot_cnt  (slot_cnt),
    .slot_lane (slot_lane)
  );

  for (genvar g = 0; g < NRT; g++) begin : g_lane
    tsq_wake_timer #(.MDW(MDW), .SHW(SHW)) u_tmr (
      .clk   (clk),
      .rst   (rst),
      .occ   (lane_occ[g]),
      .shift (lane_shift[g*SHW +: SHW]),
      .load  (iss_valid && (sel_q == lane_e'(g))),
      .field (iss_delay),
      .ready (rt_ready[g])
    );
  end

  tsq_admit #(.SHW(SHW)) u_admit (
    .change (req_change),
    .lane   (req_lane),
    .shift  (req_shift),
    .occ    (lane_occ),
    .bad    (req_bad)
  );

  assign rdy4 = {1'b0, rt_ready};

  always_comb begin
    if (slot_lane != LANE_D && rdy4[slot_lane]) pick = slot_lane;
    else                                        pick = LANE_D;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= LANE_D;
      adm_err <= 1'b0;
    end else begin
      sel_q   <= pick;
      adm_err <= req_valid && req_bad;
    end
  end

  assign sel_lane = sel_q;
endmodule

// File: rtl/tsq_sequencer_chk.sv
`timescale 1ns/1ps
module tsq_sequencer_chk #(
  parameter int SHW = 2
) (
  input logic           clk,
  input logic           rst,
  input logic [2:0]     slot_cnt,
  input logic [1:0]     slot_lane,
  input logic [2:0]     rt_ready,
  input logic [1:0]     sel_lane,
  input logic           adm_err,
  input logic [2:0]     lane_occ,
  input logic           req_valid,
  input logic           req_change,
  input logic [1:0]     req_lane,
  input logic [SHW-1:0] req_shift
);
  logic       armed;
  logic [3:0] rdy4;

  assign rdy4 = {1'b0, rt_ready};

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  p_slot_step_r1: assert property (@(posedge clk) disable iff (rst)
    armed |-> slot_cnt == 3'($past(slot_cnt) + 3'd1));

  p_owner_issues_r2: assert property (@(posedge clk) disable iff (rst)
    armed && $past(slot_lane != 2'd3 && rdy4[slot_lane]) |-> sel_lane == $past(slot_lane));

  p_idle_to_d_r3: assert property (@(posedge clk) disable iff (rst)
    armed && $past(slot_lane == 2'd3 || !rdy4[slot_lane]) |-> sel_lane == 2'd3);

  p_lane_c_shift_r6: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_lane == 2'd2 && int'(req_shift) < 3 |=> adm_err);

  p_shift1_busy_r7: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_change && req_shift == SHW'(1) && lane_occ[0] |=> adm_err);

  p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !adm_err);
endmodule

bind tsq_sequencer tsq_sequencer_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .slot_cnt   (slot_cnt),
  .slot_lane  (slot_lane),
  .rt_ready   (rt_ready),
  .sel_lane   (sel_lane),
  .adm_err    (adm_err),
  .lane_occ   (lane_occ),
  .req_valid  (req_valid),
  .req_change (req_change),
  .req_lane   (req_lane),
  .req_shift  (req_shift)
);

// File: tb/sim_tsq_sequencer.sv
`timescale 1ns/1ps
module sim_tsq_sequencer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] lane_occ = '0;
  logic [5:0] lane_shift = '0;
  logic       iss_valid = 1'b0;
  logic [1:0] iss_delay = '0;
  logic       req_valid = 1'b0;
  logic       req_change = 1'b0;
  logic [1:0] req_lane = '0;
  logic [1:0] req_shift = '0;
  logic [1:0] sel_lane;
  logic       adm_err;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  tsq_sequencer u0 (
    .clk(clk), .rst(rst), .lane_occ(lane_occ), .lane_shift(lane_shift),
    .iss_valid(iss_valid), .iss_delay(iss_delay), .req_valid(req_valid),
    .req_change(req_change), .req_lane(req_lane), .req_shift(req_shift),
    .sel_lane(sel_lane), .adm_err(adm_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  // Slot owner for counter k, taken from the requirement text.
  function automatic int owner(input int k);
    case (k % 8)
      0, 2, 4, 6: return 0;
      1, 5:       return 1;
      3:          return 2;
      default:    return 3;
    endcase
  endfunction

  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1; iss_valid = 0; req_valid = 0;
    tick; tick;
    rst = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1; lane_occ = 3'b111; lane_shift = 6'b11_10_01;
    tick; tick;
    chk("R9 reset sel_lane", sel_lane, 3);
    chk("R9 reset adm_err", adm_err, 0);
  endtask

  task automatic t_pattern(input logic [2:0] occ);
    do_reset;
    lane_occ = occ; lane_shift = 6'b11_10_01;
    for (int k = 0; k < 16; k++) begin
      int o, e;
      tick;
      o = owner(k);
      e = (o != 3 && occ[o]) ? o : 3;
      chk((e == 3) ? "R3 idle slot" : "R1 R2 slot owner", sel_lane, e);
    end
  endtask

  task automatic t_sleep_a;
    do_reset;
    lane_occ = 3'b001; lane_shift = 6'b11_10_01;
    tick; chk("R2 A issues", sel_lane, 0);
    iss_valid = 1; iss_delay = 2'd1;        // delay 4
    tick; iss_valid = 0; chk("R3 count1", sel_lane, 3);
    tick; chk("R4 A asleep at count2", sel_lane, 3);
    tick; chk("R3 count3", sel_lane, 3);
    tick; chk("R4 A wakes at count4", sel_lane, 0);
  endtask

  task automatic t_sleep_b;
    do_reset;
    lane_occ = 3'b010; lane_shift = 6'b11_10_01;
    tick; tick; chk("R2 B issues", sel_lane, 1);
    iss_valid = 1; iss_delay = 2'd2;        // delay 12
    for (int k = 2; k <= 13; k++) begin
      tick; iss_valid = 0;
      chk("R4 B delay 12", sel_lane, (k == 13) ? 1 : 3);
    end
  endtask

  task automatic t_sleep_c;
    do_reset;
    lane_occ = 3'b100; lane_shift = 6'b11_10_01;
    for (int k = 0; k < 4; k++) tick;
    chk("R2 C issues", sel_lane, 2);
    iss_valid = 1; iss_delay = 2'd1;        // delay 16
    for (int k = 4; k <= 19; k++) begin
      tick; iss_valid = 0;
      if (k == 11 || k == 19) chk("R4 C delay 16", sel_lane, (k == 19) ? 2 : 3);
    end
  endtask

  task automatic t_ignore_d;
    do_reset;
    lane_occ = 3'b001; lane_shift = 6'b11_10_01;
    for (int k = 0; k < 8; k++) tick;
    chk("R3 D slot", sel_lane, 3);
    iss_valid = 1; iss_delay = 2'd3;
    tick; iss_valid = 0; chk("R5 A after D feedback", sel_lane, 0);
    tick; tick; chk("R5 A next slot", sel_lane, 0);
  endtask

  task automatic t_vacate;
    do_reset;
    lane_occ = 3'b001; lane_shift = 6'b11_10_11;
    tick; chk("R2 A issues", sel_lane, 0);
    iss_valid = 1; iss_delay = 2'd3;        // delay 32
    tick; iss_valid = 0; lane_occ = 3'b000;
    tick; lane_occ = 3'b001; chk("R10 vacated", sel_lane, 3);
    tick; tick; chk("R10 relaunch ready", sel_lane, 0);
  endtask

  task automatic adm(input string req, input logic chg, input logic [1:0] ln,
                     input logic [1:0] sh, input logic [2:0] occ, input int exp);
    lane_occ = occ; req_valid = 1; req_change = chg; req_lane = ln; req_shift = sh;
    tick;
    req_valid = 0;
    chk(req, adm_err, exp);
  endtask

  task automatic t_admit;
    do_reset;
    adm("R6 A shift1 free",       0, 2'd0, 2'd1, 3'b000, 0);
    adm("R7 shift1 A busy",       0, 2'd0, 2'd1, 3'b001, 1);
    adm("R6 B shift1",            0, 2'd1, 2'd1, 3'b000, 1);
    adm("R6 C shift2",            0, 2'd2, 2'd2, 3'b000, 1);
    adm("R6 C shift3",            0, 2'd2, 2'd3, 3'b000, 0);
    adm("R6 lane D",              0, 2'd3, 2'd3, 3'b000, 1);
    adm("R6 shift0",              0, 2'd0, 2'd0, 3'b000, 1);
    adm("R8 A self to shift1",    1, 2'd0, 2'd1, 3'b001, 0);
    adm("R8 B to shift1",         1, 2'd1, 2'd1, 3'b011, 1);
    adm("R8 change empty C",      1, 2'd2, 2'd3, 3'b011, 1);
    adm("R7 launch into busy B",  0, 2'd1, 2'd2, 3'b010, 1);
    adm("R6 B shift2 free",       0, 2'd1, 2'd2, 3'b001, 0);
    tick;
    chk("R9 no request", adm_err, 0);
  endtask

  initial begin
    t_reset;
    t_pattern(3'b111);
    t_pattern(3'b000);
    t_pattern(3'b010);
    t_pattern(3'b101);
    t_sleep_a;
    t_sleep_b;
    t_sleep_c;
    t_ignore_d;
    t_vacate;
    t_admit;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule